// File: doc/BRIEF.md
# Capture-Compare Timer

This block is a general purpose timer built around one up-counter. The counter advances on a selectable time base: the system clock, the system clock divided by a programmable prescaler, or the rising edges of an external clock pin. The external pin is brought into the clock domain by a two-flop synchroniser before its edges are detected. Two capture inputs pass through the same kind of synchroniser. Each one latches the counter value on a rising edge, a falling edge or either edge, as selected.

Three compare channels watch the counter. On a match, or on a software strobe that forces the event, each channel drives its own output pin as programmed: hold, toggle, clear, set or a one-cycle pulse. The counter either restarts from zero after a match on compare channel 0, or runs freely and wraps. Capture, compare and wrap events set sticky status flags. Each flag has its own enable into a single interrupt line. Two gating inputs freeze the counter in low-power or debug mode unless the matching keep-running bit is set. Software reaches every register through a simple word-addressed write/read bus, and reads are combinational.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, every status flag, every capture value, every compare pin and the interrupt line are zero.
- R2: The control word sits at address 0. Bit 0 enables the counter and bits 2:1 select the time base. With code 1 (system clock) the counter, read at address 10, rises by one on every clock cycle while it runs.
- R3: With time base code 2 the counter rises once for each rising edge of extClk, after a two-flop synchroniser. While extClk is constant the counter does not move.
- R4: With time base code 3 the counter rises once every PRESC+1 cycles, where PRESC is written at address 1.
- R5: Capture channel 0 takes its edge selection from control bits 7:6 and channel 1 from bits 9:8 (0 off, 1 rising, 2 falling, 3 both). Suppose an input change is first sampled at clock edge k. Then at edge k+2 the capture register (address 8 or 9) receives the counter value held after edge k+1, and the capture flag sets. An edge that is not selected changes neither.
- R6: The compare values sit at addresses 5, 6 and 7. A match is a counting cycle in which the counter equals the compare value. The channel's flag sets at the end of the match cycle, and its pin acts one clock later. The pin actions are selected by control bits 12:10, 15:13 and 18:16 (0 hold, 1 toggle, 2 clear, 3 set, 4 high for exactly one cycle).
- R7: Writing a 1 to bit i at address 4 forces compare channel i. The flag and the pin behave as for a match, and the counter does not change.
- R8: With control bit 3 clear (restart), a match on compare channel 0 returns the counter to zero in place of the increment. With bit 3 set (free-run), that match does not disturb counting.
- R9: When the counter counts on from all ones, it becomes zero and the wrap flag sets.
- R10: The status word at address 2 holds compare flags in bits 2:0, capture flags in bits 4:3 and the wrap flag in bit 5. Flags stay set until software writes 1 to them, and writing 1 to one bit leaves the others unchanged.
- R11: irq is high exactly when some status flag is set and its enable bit, at the same position in address 3, is set.
- R12: When lowPower is high and control bit 4 is clear, or debugMode is high and control bit 5 is clear, or bit 0 is clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| extClk | input | 1 | External time base, asynchronous |
| capIn | input | 2 | Capture inputs, asynchronous |
| lowPower | input | 1 | Low-power mode indication |
| debugMode | input | 1 | Debug mode indication |
| cmpOut | output | 3 | Compare channel output pins |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The wrap flag is the hardest event to reach from the ports, because the counter must pass through every value first. The bench therefore builds the block with an 8-bit counter and runs it through a full period, checking the cycles just before and just after the wrap. Capture and compare timing are swept over every edge selection and every pin action on every channel. The expected cycle of each effect is computed from the synchroniser depth and the one-cycle pin delay.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int N_CAP  = 2;
  localparam int N_CMP  = 3;
  localparam int STAT_W = N_CMP + N_CAP + 1;
  localparam int CTRL_W = 19;

  localparam logic [1:0] SRC_OFF = 2'd0;
  localparam logic [1:0] SRC_SYS = 2'd1;
  localparam logic [1:0] SRC_EXT = 2'd2;
  localparam logic [1:0] SRC_DIV = 2'd3;

  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_FALL = 2'd2;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  localparam logic [2:0] OUT_TOGGLE = 3'd1;
  localparam logic [2:0] OUT_CLEAR  = 3'd2;
  localparam logic [2:0] OUT_SET    = 3'd3;
  localparam logic [2:0] OUT_PULSE  = 3'd4;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_PRESC = 4'd1;
  localparam logic [3:0] A_STAT  = 4'd2;
  localparam logic [3:0] A_INTEN = 4'd3;
  localparam logic [3:0] A_FORCE = 4'd4;
  localparam logic [3:0] A_CMP0  = 4'd5;
  localparam logic [3:0] A_CAP0  = 4'd8;
  localparam logic [3:0] A_COUNT = 4'd10;

  typedef struct packed {
    logic [1:0]                  clkSrc;
    logic                        freeRun;
    logic [N_CAP-1:0][1:0]       capEdge;
    logic [N_CMP-1:0][2:0]       cmpMode;
  } cfg_t;

  typedef struct packed {
    logic             run;
    logic [N_CMP-1:0] forceCmp;
  } strobe_t;

  typedef struct packed {
    logic [N_CMP-1:0] cmpHit;
    logic [N_CAP-1:0] capHit;
    logic             roll;
  } evt_t;
endpackage

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWe,
  input  logic [3:0]                    busAddr,
  input  logic [31:0]                   busWdata,
  output logic [31:0]                   busRdata,
  input  logic                          lowPower,
  input  logic                          debugMode,
  input  evt_t                          evt,
  input  logic [CNT_W-1:0]              count,
  input  logic [N_CAP-1:0][CNT_W-1:0]   capVal,
  output cfg_t                          cfg,
  output strobe_t                       stb,
  output logic [PRE_W-1:0]              presc,
  output logic [N_CMP-1:0][CNT_W-1:0]   cmpVal,
  output logic                          irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [STAT_W-1:0] statusReg, intEnReg, evtVec, clrMask;
  logic              unusedWdata;

  assign unusedWdata = &{1'b0, busWdata[31:CTRL_W]};
  assign evtVec  = {evt.roll, evt.capHit, evt.cmpHit};
  assign clrMask = (busWe && busAddr == A_STAT) ? busWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      presc     <= '0;
      statusReg <= '0;
      intEnReg  <= '0;
      cmpVal    <= '0;
    end else begin
      statusReg <= (statusReg & ~clrMask) | evtVec;
      if (busWe) begin
        if (busAddr == A_CTRL)  ctrlReg  <= busWdata[CTRL_W-1:0];
        if (busAddr == A_PRESC) presc    <= busWdata[PRE_W-1:0];
        if (busAddr == A_INTEN) intEnReg <= busWdata[STAT_W-1:0];
        for (int i = 0; i < N_CMP; i++)
          if (busAddr == A_CMP0 + 4'(i)) cmpVal[i] <= busWdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    cfg.clkSrc  = ctrlReg[2:1];
    cfg.freeRun = ctrlReg[3];
    for (int i = 0; i < N_CAP; i++) cfg.capEdge[i] = ctrlReg[6 + 2*i +: 2];
    for (int i = 0; i < N_CMP; i++) cfg.cmpMode[i] = ctrlReg[10 + 3*i +: 3];
    stb.run = ctrlReg[0] && (!lowPower || ctrlReg[4]) && (!debugMode || ctrlReg[5]);
    stb.forceCmp = (busWe && busAddr == A_FORCE) ? busWdata[N_CMP-1:0] : '0;
  end

  assign irq = |(statusReg & intEnReg);

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CTRL)  busRdata = 32'(ctrlReg);
    if (busAddr == A_PRESC) busRdata = 32'(presc);
    if (busAddr == A_STAT)  busRdata = 32'(statusReg);
    if (busAddr == A_INTEN) busRdata = 32'(intEnReg);
    if (busAddr == A_COUNT) busRdata = 32'(count);
    for (int i = 0; i < N_CMP; i++)
      if (busAddr == A_CMP0 + 4'(i)) busRdata = 32'(cmpVal[i]);
    for (int i = 0; i < N_CAP; i++)
      if (busAddr == A_CAP0 + 4'(i)) busRdata = 32'(capVal[i]);
  end

  // R10: a written 1 clears the wrap flag when no new wrap arrives
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_STAT && busWdata[STAT_W-1] && !evtVec[STAT_W-1])
      |=> !statusReg[STAT_W-1]);

  // R10: a set flag stays set unless software clears it
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[0] && !clrMask[0]) |=> statusReg[0]);
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cfg_t                          cfg,
  input  strobe_t                       stb,
  input  logic [PRE_W-1:0]              presc,
  input  logic [N_CMP-1:0][CNT_W-1:0]   cmpVal,
  input  logic                          extClk,
  input  logic [N_CAP-1:0]              capIn,
  output logic [CNT_W-1:0]              count,
  output logic [N_CAP-1:0][CNT_W-1:0]   capVal,
  output logic [N_CMP-1:0]              cmpOut,
  output evt_t                          evt
);
  logic [2:0]       extSync;
  logic             extRise;
  logic [PRE_W-1:0] preCnt;
  logic             divTick, tick;
  logic [N_CMP-1:0] cmpMatch, cmpEvt, evtQ;
  logic [N_CAP-1:0] capHit;

  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end
  assign extRise = extSync[1] & ~extSync[2];

  always_ff @(posedge clk) begin
    if (!rstN || !stb.run || cfg.clkSrc != SRC_DIV || preCnt == presc) preCnt <= '0;
    else                                                               preCnt <= preCnt + 1'b1;
  end
  assign divTick = stb.run && cfg.clkSrc == SRC_DIV && preCnt == presc;

  always_comb begin
    case (cfg.clkSrc)
      SRC_SYS: tick = stb.run;
      SRC_EXT: tick = stb.run && extRise;
      SRC_DIV: tick = divTick;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  count <= '0;
    else if (tick && !cfg.freeRun && cmpMatch[0]) count <= '0;
    else if (tick)                              count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtQ <= '0;
    else       evtQ <= cmpEvt;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign cmpMatch[g] = tick && count == cmpVal[g];
    assign cmpEvt[g]   = cmpMatch[g] || stb.forceCmp[g];

    always_ff @(posedge clk) begin
      if (!rstN) cmpOut[g] <= 1'b0;
      else if (evtQ[g]) begin
        case (cfg.cmpMode[g])
          OUT_TOGGLE: cmpOut[g] <= ~cmpOut[g];
          OUT_CLEAR:  cmpOut[g] <= 1'b0;
          OUT_SET:    cmpOut[g] <= 1'b1;
          OUT_PULSE:  cmpOut[g] <= 1'b1;
          default:    cmpOut[g] <= cmpOut[g];
        endcase
      end else if (cfg.cmpMode[g] == OUT_PULSE) cmpOut[g] <= 1'b0;
    end

    // R6: a pulse lasts a single cycle when no new event follows
    a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.cmpMode[g] == OUT_PULSE && cmpOut[g] && !evtQ[g]) |=> !cmpOut[g]);
  end

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    logic [2:0] capSync;
    logic       rise, fall;
    always_ff @(posedge clk) begin
      if (!rstN) capSync <= '0;
      else       capSync <= {capSync[1:0], capIn[g]};
    end
    assign rise = capSync[1] & ~capSync[2];
    assign fall = ~capSync[1] & capSync[2];
    assign capHit[g] = (rise && (cfg.capEdge[g] == EDGE_RISE || cfg.capEdge[g] == EDGE_BOTH)) ||
                       (fall && (cfg.capEdge[g] == EDGE_FALL || cfg.capEdge[g] == EDGE_BOTH));
    always_ff @(posedge clk) begin
      if (!rstN)        capVal[g] <= '0;
      else if (capHit[g]) capVal[g] <= count;
    end

    // R5: the capture register holds the counter of the detection cycle
    a_r5_capture_value: assert property (@(posedge clk) disable iff (!rstN)
      capHit[g] |=> capVal[g] == $past(count));
  end

  assign evt.cmpHit = cmpEvt;
  assign evt.capHit = capHit;
  assign evt.roll   = tick && (&count);

  // R12: no counting while the run strobe is low
  a_r12_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> $stable(count));

  // R9: a wrap leaves the counter at zero
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    evt.roll |=> count == '0);

  // R7: a forced compare outside a counting cycle leaves the counter alone
  a_r7_force_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (stb.forceCmp != '0 && !tick) |=> $stable(count));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        extClk,
  input  logic [1:0]  capIn,
  input  logic        lowPower,
  input  logic        debugMode,
  output logic [2:0]  cmpOut,
  output logic        irq
);
  cfg_t                          cfg;
  strobe_t                       stb;
  evt_t                          evt;
  logic [PRE_W-1:0]              presc;
  logic [N_CMP-1:0][CNT_W-1:0]   cmpVal;
  logic [N_CAP-1:0][CNT_W-1:0]   capVal;
  logic [CNT_W-1:0]              count;

  gpt_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .lowPower(lowPower), .debugMode(debugMode), .evt(evt),
    .count(count), .capVal(capVal), .cfg(cfg), .stb(stb), .presc(presc),
    .cmpVal(cmpVal), .irq(irq)
  );

  gpt_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .presc(presc), .cmpVal(cmpVal),
    .extClk(extClk), .capIn(capIn), .count(count), .capVal(capVal),
    .cmpOut(cmpOut), .evt(evt)
  );
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        extClk = 1'b0;
  logic [1:0]  capIn = '0;
  logic        lowPower = 1'b0;
  logic        debugMode = 1'b0;
  logic [2:0]  cmpOut;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  capcmp_timer #(.CNT_W(CW), .PRE_W(4)) u_capcmp_timer (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .extClk(extClk), .capIn(capIn), .lowPower(lowPower),
    .debugMode(debugMode), .cmpOut(cmpOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ctrlWord(input logic en, input logic [1:0] src,
      input logic free, input logic lp, input logic dbg, input logic [1:0] e0,
      input logic [1:0] e1, input logic [2:0] m0, input logic [2:0] m1, input logic [2:0] m2);
    return {13'b0, m2, m1, m0, e1, e0, dbg, lp, free, src, en};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0; cyc++;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    cyc += n;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; busWe = 1'b0; extClk = 1'b0; capIn = '0; lowPower = 1'b0; debugMode = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] capExp;
    int m;
    @(negedge clk);
    doReset();

    // R1 reset state
    rd(A_COUNT_B(), v); chk("R1 count", v, 0);
    rd(4'd2, v);  chk("R1 status", v, 0);
    rd(4'd8, v);  chk("R1 capture0", v, 0);
    rd(4'd9, v);  chk("R1 capture1", v, 0);
    chk("R1 pins", 32'(cmpOut), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 system clock
    wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 0)); cyc = 0;
    step(7); rd(4'd10, v); chk("R2 sys count", v, 7);

    // R4 prescaler sweep
    for (int p = 0; p < 5; p++) begin
      doReset();
      wr(4'd1, p);
      wr(4'd0, ctrlWord(1, 2'd3, 1, 0, 0, 0, 0, 0, 0, 0)); cyc = 0;
      step(24); rd(4'd10, v); chk("R4 prescaled count", v, 24 / (p + 1));
    end

    // R3 external clock
    doReset();
    wr(4'd0, ctrlWord(1, 2'd2, 1, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 6; k++) begin
      extClk = 1'b1; step(2); extClk = 1'b0; step(2);
    end
    step(4); rd(4'd10, v); chk("R3 ext edges", v, 6);
    step(5); rd(4'd10, v); chk("R3 ext idle", v, 6);

    // R8 restart mode
    doReset();
    wr(4'd5, 4);
    wr(4'd0, ctrlWord(1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0)); cyc = 0;
    for (int k = 1; k <= 12; k++) begin
      step(1); rd(4'd10, v); chk("R8 restart count", v, k % 5);
    end
    doReset();
    wr(4'd5, 4);
    wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 0)); cyc = 0;
    step(8); rd(4'd10, v); chk("R8 free-run passes match", v, 8);

    // R9 wrap, R11 irq, R10 write-one-to-clear
    doReset();
    wr(4'd3, 32'h20);
    wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 0)); cyc = 0;
    step(255);
    rd(4'd10, v); chk("R9 count before wrap", v, 255);
    rd(4'd2, v);  chk("R9 flag before wrap", (v >> 5) & 1, 0);
    chk("R11 irq before wrap", 32'(irq), 0);
    step(1);
    rd(4'd10, v); chk("R9 count after wrap", v, 0);
    rd(4'd2, v);  chk("R9 flag after wrap", (v >> 5) & 1, 1);
    chk("R11 irq after wrap", 32'(irq), 1);
    wr(4'd2, 32'h20);
    rd(4'd2, v);  chk("R10 clear one flag", v, 32'h07);
    chk("R11 irq after clear", 32'(irq), 0);
    wr(4'd2, 32'h07);
    rd(4'd2, v);  chk("R10 clear rest", v, 0);

    // R6 compare pin actions on every channel
    for (int ch = 0; ch < 3; ch++) begin
      for (int md = 0; md < 5; md++) begin
        logic e1;
        logic e2;
        e1 = (md == 1 || md == 3 || md == 4);
        e2 = (md == 4) ? 1'b0 : e1;
        doReset();
        wr(4'd5 + 4'(ch), 4);
        wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, 0, 0,
                          ch == 0 ? 3'(md) : 3'd0, ch == 1 ? 3'(md) : 3'd0,
                          ch == 2 ? 3'(md) : 3'd0)); cyc = 0;
        step(4); rd(4'd2, v); chk("R6 flag before match", (v >> ch) & 1, 0);
        step(1); rd(4'd2, v); chk("R6 flag at match", (v >> ch) & 1, 1);
        chk("R6 pin unchanged at match", 32'(cmpOut[ch]), 0);
        chk("R11 irq masked", 32'(irq), 0);
        step(1); chk("R6 pin one cycle later", 32'(cmpOut[ch]), 32'(e1));
        step(1); chk("R6 pin two cycles later", 32'(cmpOut[ch]), 32'(e2));
      end
    end

    // R7 forced compare with the counter stopped
    doReset();
    wr(4'd0, ctrlWord(0, 2'd1, 1, 0, 0, 0, 0, 0, 3'd3, 0));
    wr(4'd4, 32'h2);
    rd(4'd2, v); chk("R7 forced flag only ch1", v, 32'h2);
    chk("R7 pin waits a cycle", 32'(cmpOut), 0);
    step(1); chk("R7 forced set", 32'(cmpOut), 32'h2);
    wr(4'd0, ctrlWord(0, 2'd1, 1, 0, 0, 0, 0, 0, 3'd2, 0));
    wr(4'd4, 32'h2);
    step(1); chk("R7 forced clear", 32'(cmpOut), 0);
    wr(4'd0, ctrlWord(0, 2'd1, 1, 0, 0, 0, 0, 3'd1, 0, 0));
    wr(4'd4, 32'h1); step(1); chk("R7 forced toggle on", 32'(cmpOut), 32'h1);
    wr(4'd4, 32'h1); step(1); chk("R7 forced toggle off", 32'(cmpOut), 0);
    rd(4'd10, v); chk("R7 counter untouched", v, 0);

    // R5 capture edge sweep
    for (int ch = 0; ch < 2; ch++) begin
      for (int md = 0; md < 4; md++) begin
        logic onRise;
        logic onFall;
        onRise = (md == 1 || md == 3);
        onFall = (md == 2 || md == 3);
        doReset();
        wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, ch == 0 ? 2'(md) : 2'd0,
                          ch == 1 ? 2'(md) : 2'd0, 0, 0, 0)); cyc = 0;
        step(3);
        capIn[ch] = 1'b1; m = cyc;
        step(3);
        capExp = onRise ? 32'(m + 2) : 32'd0;
        rd(4'd2, v); chk("R5 rise flag", (v >> (3 + ch)) & 1, 32'(onRise));
        rd(4'd8 + 4'(ch), v); chk("R5 rise value", v, capExp);
        wr(4'd2, 32'h18);
        step(2);
        capIn[ch] = 1'b0; m = cyc;
        step(3);
        if (onFall) capExp = 32'(m + 2);
        rd(4'd2, v); chk("R5 fall flag", (v >> (3 + ch)) & 1, 32'(onFall));
        rd(4'd8 + 4'(ch), v); chk("R5 fall value", v, capExp);
      end
    end

    // R12 low-power and debug gating
    doReset();
    lowPower = 1'b1;
    wr(4'd0, ctrlWord(1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 0));
    step(5); rd(4'd10, v); chk("R12 frozen in low power", v, 0);
    wr(4'd0, ctrlWord(1, 2'd1, 1, 1, 0, 0, 0, 0, 0, 0));
    step(4); rd(4'd10, v); chk("R12 kept running in low power", v, 4);
    debugMode = 1'b1;
    step(3); rd(4'd10, v); chk("R12 frozen in debug", v, 4);
    wr(4'd0, ctrlWord(1, 2'd1, 1, 1, 1, 0, 0, 0, 0, 0));
    step(3); rd(4'd10, v); chk("R12 kept running in debug", v, 7);
    wr(4'd0, ctrlWord(0, 2'd1, 1, 1, 1, 0, 0, 0, 0, 0));
    step(3); rd(4'd10, v); chk("R12 disabled holds", v, 8);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  function automatic logic [3:0] A_COUNT_B();
    return 4'd10;
  endfunction
endmodule